// File: doc/BRIEF.md
# Serial Shift Clock and Counter Controller

This block is the clocking and control core of a general-purpose serial port. It holds a control register with two interrupt enables, a two-bit wire mode, a two-bit clock source select and two write-only strobes. From these settings it derives one shift pulse per clock. Each pulse advances a bit counter and shifts an eight-bit data register left. The data register takes in the sampled serial input at bit 0.

A shift clock can come from three places. Software can pulse it with the strobe bits. A timer compare-match pulse can drive it. The serial clock pin can drive it, on the rising edge or on the falling edge. When an external clock is selected, software can also emulate that external clock with the toggle strobe. The external clock and data inputs are sampled in every wire mode, including the mode where all outputs are off. The wire mode field only reaches the pin output logic outside this block.

When the counter wraps, a sticky overflow flag is set. The overflow flag and an externally detected start flag each request an interrupt, gated by the flag's own enable bit and by a global interrupt enable input.

Top module: `ser_clk_ctrl`

## Requirements
- R1: After reset, the register readback, the wire mode, the counter, the data register, the overflow flag and both interrupt requests are all 0.
- R2: The register is bit 7 start interrupt enable, bit 6 overflow interrupt enable, bits 5:4 wire mode, bits 3:2 clock select, bit 1 clock strobe and bit 0 toggle strobe. Bits 7:2 read back as last written. Bits 1:0 always read 0. `wire_mode_o` carries bits 5:4.
- R3: The stored clock select chooses the hardware clock: 00 software only, 01 timer match, 10 serial clock rising edge, 11 serial clock falling edge. Every selected clock advances the counter by exactly one, modulo 16. A clock that is not selected has no effect.
- R4: A register write with bit 1 set and written select 00 is one software clock. A write with bit 3 set and both bits 1 and 0 set is one emulated external clock. Any other combination of the strobes gives no clock.
- R5: The serial clock pin passes through a two-flop synchronizer before edge detection. A pin edge counts on the third rising clock edge after the pin changes. This holds in every wire mode, including 00.
- R6: `irq_ovf_o` is the overflow flag AND bit 6 AND `gie_i`. `irq_start_o` is `start_flag_i` AND bit 7 AND `gie_i`. Both are combinational.
- R7: A shift clock while the counter is 15 takes the counter to 0 and sets a sticky overflow flag. A pulse on `ovf_clr_i` clears the flag. If a set and a clear happen in the same cycle, the set wins.
- R8: Each shift clock shifts the data register left and loads the two-flop synchronized `sdi_i` into bit 0.
- R9: A software strobe and a hardware clock in the same cycle advance the counter and the data register only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Control register readback, strobe bits as 0 |
| wire_mode_o | output | 2 | Wire mode field for the pin output logic |
| sck_i | input | 1 | Serial clock pin, asynchronous |
| sdi_i | input | 1 | Serial data input pin, asynchronous |
| timer_match_i | input | 1 | Timer compare-match pulse |
| start_flag_i | input | 1 | Pending start condition flag from the detector |
| gie_i | input | 1 | Global interrupt enable |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| shift_en_o | output | 1 | Shift pulse for the current cycle |
| cnt_o | output | 4 | Bit counter |
| data_o | output | 8 | Data shift register |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| irq_ovf_o | output | 1 | Overflow interrupt request |
| irq_start_o | output | 1 | Start condition interrupt request |

## Verification
A register write or a timer pulse that is held across one rising edge moves the counter at that edge. The bench checks the result at the falling edge that follows. A serial clock pin edge takes effect on the third rising edge after the pin changes. After each pin change the bench waits three full cycles before it samples. Serial data is set up two cycles before each strobe. The interrupt outputs are combinational, so the bench reads them half a cycle after it drives the gating inputs.

// File: rtl/ser_clk_pkg.sv
package ser_clk_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned SIE_B  = 7;
  localparam int unsigned OIE_B  = 6;
  localparam int unsigned WM_HI  = 5;
  localparam int unsigned WM_LO  = 4;
  localparam int unsigned CS_HI  = 3;
  localparam int unsigned CS_LO  = 2;
  localparam int unsigned CLK_B  = 1;
  localparam int unsigned TGL_B  = 0;

  typedef enum logic [1:0] {
    CS_SOFT     = 2'b00,
    CS_TIMER    = 2'b01,
    CS_EXT_RISE = 2'b10,
    CS_EXT_FALL = 2'b11
  } clk_sel_e;
endpackage

// File: rtl/ser_ctrl_reg.sv
module ser_ctrl_reg
  import ser_clk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             sie_o,
  output logic             oie_o,
  output logic [1:0]       wm_o,
  output clk_sel_e         cs_o,
  output logic             sw_tick_o
);
  logic [REG_W-1:TGL_B+2] q;
  logic                   wr_soft;
  logic                   wr_emul;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (wr_i) q <= wdata_i[REG_W-1:TGL_B+2];
  end

  assign rdata_o = {q, 2'b00};
  assign sie_o   = q[SIE_B];
  assign oie_o   = q[OIE_B];
  assign wm_o    = q[WM_HI:WM_LO];
  assign cs_o    = clk_sel_e'(q[CS_HI:CS_LO]);

  // strobes act on the select value written in the same access
  assign wr_soft   = (wdata_i[CS_HI:CS_LO] == CS_SOFT) && wdata_i[CLK_B];
  assign wr_emul   = wdata_i[CS_HI] && wdata_i[CLK_B] && wdata_i[TGL_B];
  assign sw_tick_o = wr_i && (wr_soft || wr_emul);
endmodule

// File: rtl/ser_clk_sel.sv
module ser_clk_sel
  import ser_clk_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  clk_sel_e cs_i,
  input  logic     sck_i,
  input  logic     sdi_i,
  input  logic     timer_match_i,
  output logic     hw_tick_o,
  output logic     sdi_sync_o
);
  logic [SYNC_STAGES-1:0] sck_sync;
  logic [SYNC_STAGES-1:0] sdi_sync;
  logic                   sck_prev;
  logic                   rise;
  logic                   fall;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) begin
            sck_sync[0] <= 1'b0;
            sdi_sync[0] <= 1'b0;
          end else begin
            sck_sync[0] <= sck_i;
            sdi_sync[0] <= sdi_i;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) begin
            sck_sync[g] <= 1'b0;
            sdi_sync[g] <= 1'b0;
          end else begin
            sck_sync[g] <= sck_sync[g-1];
            sdi_sync[g] <= sdi_sync[g-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_prev <= 1'b0;
    else         sck_prev <= sck_sync[SYNC_STAGES-1];
  end

  assign rise       = sck_sync[SYNC_STAGES-1] & ~sck_prev;
  assign fall       = ~sck_sync[SYNC_STAGES-1] & sck_prev;
  assign sdi_sync_o = sdi_sync[SYNC_STAGES-1];

  always_comb begin
    unique case (cs_i)
      CS_TIMER:    hw_tick_o = timer_match_i;
      CS_EXT_RISE: hw_tick_o = rise;
      CS_EXT_FALL: hw_tick_o = fall;
      default:     hw_tick_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ser_bit_cnt.sv
module ser_bit_cnt #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic wrap;
  assign wrap = tick_i && (cnt_o == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (tick_i) cnt_o <= cnt_o + 1'b1;
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ovf_o <= 1'b0;
    else if (wrap)  ovf_o <= 1'b1;
    else if (clr_i) ovf_o <= 1'b0;
  end
endmodule

// File: rtl/ser_shift_reg.sv
module ser_shift_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              din_i,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_o <= '0;
    else if (shift_i) data_o <= {data_o[DATA_W-2:0], din_i};
  end
endmodule

// File: rtl/ser_clk_ctrl.sv
module ser_clk_ctrl
  import ser_clk_pkg::*;
#(
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic [1:0]        wire_mode_o,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic              timer_match_i,
  input  logic              start_flag_i,
  input  logic              gie_i,
  input  logic              ovf_clr_i,
  output logic              shift_en_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ovf_flag_o,
  output logic              irq_ovf_o,
  output logic              irq_start_o
);
  logic     sie;
  logic     oie;
  clk_sel_e cs;
  logic     sw_tick;
  logic     hw_tick;
  logic     sdi_s;

  ser_ctrl_reg u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reg_wr_i),
    .wdata_i   (reg_wdata_i),
    .rdata_o   (reg_rdata_o),
    .sie_o     (sie),
    .oie_o     (oie),
    .wm_o      (wire_mode_o),
    .cs_o      (cs),
    .sw_tick_o (sw_tick)
  );

  ser_clk_sel #(.SYNC_STAGES(SYNC_STAGES)) u_sel (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cs_i          (cs),
    .sck_i         (sck_i),
    .sdi_i         (sdi_i),
    .timer_match_i (timer_match_i),
    .hw_tick_o     (hw_tick),
    .sdi_sync_o    (sdi_s)
  );

  // one pulse even when both sources fire
  assign shift_en_o = sw_tick | hw_tick;

  ser_bit_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (shift_en_o),
    .clr_i  (ovf_clr_i),
    .cnt_o  (cnt_o),
    .ovf_o  (ovf_flag_o)
  );

  ser_shift_reg #(.DATA_W(DATA_W)) u_sr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (shift_en_o),
    .din_i   (sdi_s),
    .data_o  (data_o)
  );

  assign irq_ovf_o   = ovf_flag_o & oie & gie_i;
  assign irq_start_o = start_flag_i & sie & gie_i;
endmodule

// File: rtl/ser_clk_ctrl_chk.sv
module ser_clk_ctrl_chk #(
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [7:0]        reg_rdata_o,
  input logic              gie_i,
  input logic              ovf_clr_i,
  input logic              shift_en_o,
  input logic [CNT_W-1:0]  cnt_o,
  input logic [DATA_W-1:0] data_o,
  input logic              ovf_flag_o,
  input logic              irq_ovf_o,
  input logic              irq_start_o
);
  a_r2_strobes_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[1:0] == 2'b00);

  a_r3_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_o |=> cnt_o == $past(cnt_o) + 1'b1);

  a_r3_count_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en_o |=> $stable(cnt_o));

  a_r6_gie_gates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_i |-> (!irq_ovf_o && !irq_start_o));

  a_r7_wrap_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_en_o && cnt_o == {CNT_W{1'b1}}) |=> (ovf_flag_o && cnt_o == '0));

  a_r7_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_flag_o && !ovf_clr_i) |=> ovf_flag_o);

  a_r8_shift_left: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_o |=> data_o[DATA_W-1:1] == $past(data_o[DATA_W-2:0]));

  a_r8_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en_o |=> $stable(data_o));
endmodule

bind ser_clk_ctrl ser_clk_ctrl_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_rdata_o (reg_rdata_o),
  .gie_i       (gie_i),
  .ovf_clr_i   (ovf_clr_i),
  .shift_en_o  (shift_en_o),
  .cnt_o       (cnt_o),
  .data_o      (data_o),
  .ovf_flag_o  (ovf_flag_o),
  .irq_ovf_o   (irq_ovf_o),
  .irq_start_o (irq_start_o)
);

// File: tb/ser_clk_ctrl_tb.sv
module ser_clk_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_wr_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic [1:0] wire_mode_o;
  logic       sck_i = 1'b0;
  logic       sdi_i = 1'b0;
  logic       timer_match_i = 1'b0;
  logic       start_flag_i = 1'b0;
  logic       gie_i = 1'b0;
  logic       ovf_clr_i = 1'b0;
  logic       shift_en_o;
  logic [3:0] cnt_o;
  logic [7:0] data_o;
  logic       ovf_flag_o;
  logic       irq_ovf_o;
  logic       irq_start_o;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  ser_clk_ctrl u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .reg_wr_i      (reg_wr_i),
    .reg_wdata_i   (reg_wdata_i),
    .reg_rdata_o   (reg_rdata_o),
    .wire_mode_o   (wire_mode_o),
    .sck_i         (sck_i),
    .sdi_i         (sdi_i),
    .timer_match_i (timer_match_i),
    .start_flag_i  (start_flag_i),
    .gie_i         (gie_i),
    .ovf_clr_i     (ovf_clr_i),
    .shift_en_o    (shift_en_o),
    .cnt_o         (cnt_o),
    .data_o        (data_o),
    .ovf_flag_o    (ovf_flag_o),
    .irq_ovf_o     (irq_ovf_o),
    .irq_start_o   (irq_start_o)
  );

  // op kinds: 0 write, 1 timer pulse, 2 sck high, 3 sck low
  // entry = {kind[1:0], wdata[7:0], expected cnt[3:0]}
  localparam int NV = 18;
  localparam logic [13:0] VEC [NV] = '{
    {2'd0, 8'h02, 4'd1},  // R4 soft strobe
    {2'd0, 8'h02, 4'd2},
    {2'd0, 8'h01, 4'd2},  // R4 toggle alone ignored
    {2'd0, 8'h04, 4'd2},  // select timer
    {2'd1, 8'h00, 4'd3},  // R3 timer
    {2'd1, 8'h00, 4'd4},
    {2'd0, 8'h06, 4'd4},  // R4 strobe under timer select ignored
    {2'd0, 8'h08, 4'd4},  // rising edge, wire mode 00
    {2'd2, 8'h00, 4'd5},  // R5 rise
    {2'd3, 8'h00, 4'd5},  // fall ignored
    {2'd2, 8'h00, 4'd6},
    {2'd1, 8'h00, 4'd6},  // R3 timer not selected
    {2'd0, 8'h0B, 4'd7},  // R4 emulated external clock
    {2'd0, 8'h09, 4'd7},  // toggle without clock strobe
    {2'd0, 8'h0C, 4'd7},  // falling edge
    {2'd3, 8'h00, 4'd8},  // R5 fall
    {2'd2, 8'h00, 4'd8},
    {2'd0, 8'h0E, 4'd8}
  };

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    reg_wr_i = 1'b1;
    reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic tmr();
    @(negedge clk);
    timer_match_i = 1'b1;
    @(negedge clk);
    timer_match_i = 1'b0;
  endtask

  task automatic sck(input logic v);
    @(negedge clk);
    sck_i = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [3:0] c;
    logic [7:0] pat;
    repeat (2) @(negedge clk);
    chk(reg_rdata_o == 8'h00 && cnt_o == 4'h0 && data_o == 8'h00 && wire_mode_o == 2'b00,
        "R1 reset state", {reg_rdata_o, cnt_o}, 0);
    chk(!ovf_flag_o && !irq_ovf_o && !irq_start_o, "R1 reset flags", ovf_flag_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R3 R4 R5 table
    for (int i = 0; i < NV; i++) begin
      logic [1:0] k;
      k = VEC[i][13:12];
      case (k)
        2'd0: wr(VEC[i][11:4]);
        2'd1: tmr();
        2'd2: sck(1'b1);
        default: sck(1'b0);
      endcase
      chk(cnt_o == VEC[i][3:0], $sformatf("R3 R4 R5 table step %0d", i), cnt_o, VEC[i][3:0]);
    end

    // R2 readback and wire mode
    wr(8'hFC);
    chk(reg_rdata_o == 8'hFC && wire_mode_o == 2'b11, "R2 readback", reg_rdata_o, 8'hFC);
    wr(8'hFF);
    chk(reg_rdata_o == 8'hFC, "R2 strobes read 0", reg_rdata_o, 8'hFC);
    chk(cnt_o == 4'd9, "R4 full strobe write", cnt_o, 9);

    // R5 external clock in any wire mode
    wr(8'h38);
    sck(1'b0);
    sck(1'b1);
    chk(cnt_o == 4'd10, "R5 wire mode 11 rise", cnt_o, 10);
    wr(8'h08);
    sck(1'b0);
    sck(1'b1);
    chk(cnt_o == 4'd11 && wire_mode_o == 2'b00, "R5 wire mode 00 rise", cnt_o, 11);

    // R8 serial data shift, wraps counter on the way
    wr(8'h00);
    pat = 8'hA5;
    for (int b = 7; b >= 0; b--) begin
      sdi_i = pat[b];
      repeat (2) @(negedge clk);
      wr(8'h02);
    end
    chk(data_o == 8'hA5, "R8 shifted pattern", data_o, 8'hA5);
    chk(cnt_o == 4'd3, "R3 count after 8", cnt_o, 3);
    chk(ovf_flag_o, "R7 flag after wrap", ovf_flag_o, 1);

    // R6 overflow interrupt gating
    wr(8'h40);
    gie_i = 1'b1;
    @(negedge clk);
    chk(irq_ovf_o, "R6 ovf irq on", irq_ovf_o, 1);
    gie_i = 1'b0;
    @(negedge clk);
    chk(!irq_ovf_o, "R6 ovf irq gie off", irq_ovf_o, 0);
    @(negedge clk);
    ovf_clr_i = 1'b1;
    @(negedge clk);
    ovf_clr_i = 1'b0;
    chk(!ovf_flag_o, "R7 flag clear", ovf_flag_o, 0);

    // R7 exact wrap point
    for (int n = 0; n < 12; n++) wr(8'h42);
    chk(cnt_o == 4'd15 && !ovf_flag_o, "R7 at 15 no flag", {ovf_flag_o, cnt_o}, 15);
    wr(8'h42);
    chk(cnt_o == 4'd0 && ovf_flag_o, "R7 wrap to 0", {ovf_flag_o, cnt_o}, 16);

    // R7 set beats clear
    for (int n = 0; n < 15; n++) wr(8'h42);
    @(negedge clk);
    reg_wr_i = 1'b1;
    reg_wdata_i = 8'h42;
    ovf_clr_i = 1'b1;
    @(negedge clk);
    reg_wr_i = 1'b0;
    ovf_clr_i = 1'b0;
    chk(ovf_flag_o && cnt_o == 4'd0, "R7 set over clear", ovf_flag_o, 1);

    // R9 coincident strobe and timer
    wr(8'h44);
    c = cnt_o;
    pat = data_o;
    @(negedge clk);
    timer_match_i = 1'b1;
    reg_wr_i = 1'b1;
    reg_wdata_i = 8'h42;
    @(negedge clk);
    timer_match_i = 1'b0;
    reg_wr_i = 1'b0;
    chk(cnt_o == c + 4'd1, "R9 single step", cnt_o, c + 4'd1);
    chk(data_o == {pat[6:0], sdi_i}, "R9 single shift", data_o, {pat[6:0], sdi_i});

    // R6 start interrupt gating
    start_flag_i = 1'b1;
    wr(8'h80);
    gie_i = 1'b1;
    @(negedge clk);
    chk(irq_start_o, "R6 start irq on", irq_start_o, 1);
    wr(8'h00);
    chk(!irq_start_o, "R6 start irq disabled", irq_start_o, 0);
    start_flag_i = 1'b0;
    gie_i = 1'b0;

    // R1 reset mid-run
    rst_ni = 1'b0;
    @(negedge clk);
    chk(cnt_o == 4'h0 && data_o == 8'h00 && reg_rdata_o == 8'h00 && !ovf_flag_o,
        "R1 reset again", {cnt_o, data_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule